// File: doc/BRIEF.md
# Clock Monitor Self-Clock Switch

This block chooses the system clock from three sources: the crystal oscillator, the PLL output and a free-running VCO held at its lowest frequency. In normal operation it passes either the oscillator or the PLL, as the PLL-select request asks. When the oscillator is missing it falls back to the minimum-frequency VCO. The cause can be a failure at run time or a crystal that has not yet finished starting after reset. Fallback is allowed only when both the clock-monitor enable and the self-clock enable are set.

Entering fallback forces the effective PLL selection to zero. Once the oscillator is reported good again, the block returns to normal mode by itself. If the monitor is enabled but fallback is not, a lost oscillator raises a reset request instead of causing a switch.

The control logic runs on the VCO clock, which is always running. Each source reaches the output through its own gate. A gate opens only after every other gate has closed, and each gate is synchronised in the clock domain of its own source. The gate of a dead oscillator is cleared asynchronously, because that clock gives it no edges to close on.

Top module: `clkmon_sysclk_sel`

## Requirements
- R1: While rst_n is low, scm_active, pll_sel_eff, mode_chg and cm_rst_req are all 0.
- R2: With cme=1 and scme=1, a low osc_good sets scm_active to 1, and sys_clk then toggles at the VCO rate.
- R3: With cme=0, a low osc_good causes neither fallback nor a reset request.
- R4: With cme=1 and scme=0, a low osc_good raises cm_rst_req without fallback. cm_rst_req drops again once osc_good returns.
- R5: Entering fallback clears pll_sel_eff. After the return to normal it stays 0 until pll_sel_req is taken low and raised again.
- R6: In fallback, a high osc_good returns the block to normal mode, and sys_clk toggles at the oscillator rate again.
- R7: If osc_good is low when reset is released and both enables are set, the block enters fallback directly (slow crystal start-up).
- R8: Every change of scm_active produces exactly one mode_chg pulse, one VCO cycle long, and mode_chg is never high otherwise.
- R9: In normal mode, sys_clk follows pll_clk when pll_sel_eff is 1 and osc_clk when it is 0. pll_sel_eff becomes 1 on a rising edge of pll_sel_req and becomes 0 when pll_sel_req is low.
- R10: Switching never produces a high or low phase on sys_clk shorter than the shortest half period of any source, and at most one gate is open at any time.
- R11: In fallback, a rising edge of pll_sel_req leaves pll_sel_eff at 0.
- R12: Fallback ends only when the oscillator recovers; taking scme low during fallback has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| vco_clk | input | 1 | Free-running minimum-frequency VCO clock; clocks the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cme | input | 1 | Clock-monitor enable |
| scme | input | 1 | Self-clock (fallback) enable |
| pll_sel_req | input | 1 | Request to run from the PLL |
| osc_good | input | 1 | Oscillator-present indication from the quality checker |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| scm_active | output | 1 | High while in self-clock fallback |
| pll_sel_eff | output | 1 | Effective PLL selection |
| mode_chg | output | 1 | One-cycle pulse on each mode change |
| cm_rst_req | output | 1 | Reset request on a clock loss that fallback does not cover |

## Verification
The sources run at three different rates (VCO 250 MHz, PLL about 167 MHz, oscillator 100 MHz), so counting sys_clk edges over a fixed window shows which source is gated through. The bench loses the oscillator under three enable patterns: both enables set, monitor off, and monitor on with fallback off. These show which of the three pairs of outcomes follows: fallback, nothing, or a reset request. Toggling the PLL request before fallback, during fallback and after recovery shows whether pll_sel_eff is edge-set, whether entry clears it and whether the hold works. A reset taken with the oscillator stopped separates the start-up path from a loss at run time. A pulse-width monitor on sys_clk runs through every switch.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_OSC = 0;
    localparam int SRC_PLL = 1;
    localparam int SRC_VCO = 2;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SELF   = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  pll_sel;
        logic  req_prev;
        logic  chg;
        logic  rst_req;
    } ctrl_s;
endpackage

// File: rtl/scs_sync.sv
`timescale 1ns/1ps
module scs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/scs_ctrl.sv
`timescale 1ns/1ps
module scs_ctrl
    import scs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cme,
    input  logic scme,
    input  logic pll_req,
    input  logic osc_good,
    output logic mode_self,
    output logic pll_sel,
    output logic mode_chg,
    output logic rst_req,
    output logic osc_ok_s
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw, synced;
    logic cme_s, scme_s, req_s;
    ctrl_s r_d, r_q;

    assign raw = {cme, scme, pll_req, osc_good};

    scs_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    assign {cme_s, scme_s, req_s, osc_ok_s} = synced;

    always_comb begin
        r_d = r_q;
        case (r_q.mode)
            MODE_NORMAL: if (cme_s && scme_s && !osc_ok_s) r_d.mode = MODE_SELF;
            MODE_SELF:   if (osc_ok_s)                     r_d.mode = MODE_NORMAL;
            default:     r_d.mode = MODE_NORMAL;
        endcase
        r_d.req_prev = req_s;
        if (r_d.mode == MODE_SELF || !req_s) begin
            r_d.pll_sel = 1'b0;
        end else if (!r_q.req_prev) begin
            r_d.pll_sel = 1'b1;
        end
        r_d.chg     = (r_d.mode != r_q.mode);
        r_d.rst_req = (r_d.mode == MODE_NORMAL) && cme_s && !scme_s && !osc_ok_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: MODE_NORMAL, default: 1'b0};
        else        r_q <= r_d;
    end

    assign mode_self = (r_q.mode == MODE_SELF);
    assign pll_sel   = r_q.pll_sel;
    assign mode_chg  = r_q.chg;
    assign rst_req   = r_q.rst_req;
endmodule

// File: rtl/scs_gate_branch.sv
`timescale 1ns/1ps
module scs_gate_branch #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic force_off,
    input  logic want,
    output logic en,
    output logic clk_out
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic arst_n;

    assign arst_n = rst_n & ~force_off;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], want};
    end

    always_ff @(negedge clk_src or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign en      = chain_q[STAGES-1];
    assign clk_out = clk_src & en;
endmodule

// File: rtl/clkmon_sysclk_sel.sv
`timescale 1ns/1ps
module clkmon_sysclk_sel
    import scs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic pll_clk,
    input  logic vco_clk,
    input  logic rst_n,
    input  logic cme,
    input  logic scme,
    input  logic pll_sel_req,
    input  logic osc_good,
    output logic sys_clk,
    output logic scm_active,
    output logic pll_sel_eff,
    output logic mode_chg,
    output logic cm_rst_req
);
    logic [NSRC-1:0] src_clk, sel, en, gated;
    logic mode_self, pll_sel, osc_ok_s;

    scs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .cme      (cme),
        .scme     (scme),
        .pll_req  (pll_sel_req),
        .osc_good (osc_good),
        .mode_self(mode_self),
        .pll_sel  (pll_sel),
        .mode_chg (mode_chg),
        .rst_req  (cm_rst_req),
        .osc_ok_s (osc_ok_s)
    );

    assign src_clk[SRC_OSC] = osc_clk;
    assign src_clk[SRC_PLL] = pll_clk;
    assign src_clk[SRC_VCO] = vco_clk;

    always_comb begin
        sel = '0;
        if (mode_self)    sel[SRC_VCO] = 1'b1;
        else if (pll_sel) sel[SRC_PLL] = 1'b1;
        else              sel[SRC_OSC] = 1'b1;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic others_on, want, force_off;
        assign others_on = |(en & ~(NSRC'(1) << g));
        assign want      = sel[g] & ~others_on;
        if (g == SRC_OSC) begin : g_kill
            assign force_off = mode_self;
        end else begin : g_keep
            assign force_off = 1'b0;
        end
        scs_gate_branch #(.STAGES(SYNC_STAGES)) u_gate (
            .clk_src  (src_clk[g]),
            .rst_n    (rst_n),
            .force_off(force_off),
            .want     (want),
            .en       (en[g]),
            .clk_out  (gated[g])
        );
    end

    assign sys_clk     = |gated;
    assign scm_active  = mode_self;
    assign pll_sel_eff = pll_sel;
endmodule

// File: rtl/scs_sva.sv
`timescale 1ns/1ps
module scs_sva
    import scs_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            scm_active,
    input logic            pll_sel_eff,
    input logic            mode_chg,
    input logic            cm_rst_req,
    input logic            osc_ok_s,
    input logic [NSRC-1:0] en
);
    a_r5_no_pll_in_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        scm_active |-> !pll_sel_eff);

    a_r4_req_only_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
        cm_rst_req |-> !scm_active);

    a_r8_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg == (scm_active != $past(scm_active)));

    a_r10_one_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en));

    a_r12_stay_until_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_active && !osc_ok_s) |=> scm_active);

    a_r6_exit_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scm_active) |-> $past(osc_ok_s));
endmodule

bind clkmon_sysclk_sel scs_sva u_sva (
    .clk        (vco_clk),
    .rst_n      (rst_n),
    .scm_active (scm_active),
    .pll_sel_eff(pll_sel_eff),
    .mode_chg   (mode_chg),
    .cm_rst_req (cm_rst_req),
    .osc_ok_s   (osc_ok_s),
    .en         (en)
);

// File: tb/clkmon_sysclk_sel_tb.sv
`timescale 1ns/1ps
module clkmon_sysclk_sel_tb_top;
    logic osc_clk = 0, pll_clk = 0, vco_clk = 0;
    logic rst_n = 0, cme = 1, scme = 1, pll_sel_req = 0, osc_good = 0;
    logic osc_run = 1;
    logic sys_clk, scm_active, pll_sel_eff, mode_chg, cm_rst_req;

    int nchk = 0, nerr = 0;
    int edge_cnt = 0, pulse_cnt = 0, glitch_cnt = 0;
    bit done = 0;
    realtime last_t = 0.0;

    localparam int WIN_NS = 240;
    localparam int RATE_VCO = 60, RATE_PLL = 40, RATE_OSC = 24;

    clkmon_sysclk_sel dut_i (
        .osc_clk(osc_clk), .pll_clk(pll_clk), .vco_clk(vco_clk),
        .rst_n(rst_n), .cme(cme), .scme(scme),
        .pll_sel_req(pll_sel_req), .osc_good(osc_good),
        .sys_clk(sys_clk), .scm_active(scm_active), .pll_sel_eff(pll_sel_eff),
        .mode_chg(mode_chg), .cm_rst_req(cm_rst_req)
    );

    initial forever #2 vco_clk = ~vco_clk;
    initial forever #3 pll_clk = ~pll_clk;
    initial forever begin
        #5;
        if (osc_run) osc_clk = ~osc_clk;
        else         osc_clk = 1'b0;
    end

    always @(posedge sys_clk) edge_cnt++;
    always @(negedge vco_clk) if (mode_chg) pulse_cnt++;
    always @(sys_clk) begin
        if (rst_n && ($realtime - last_t) < 1.9) glitch_cnt++;
        last_t = $realtime;
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rate(string req, int exp);
        int c0, d;
        @(negedge vco_clk);
        c0 = edge_cnt;
        #(WIN_NS);
        d = edge_cnt - c0;
        nchk++;
        if (d < exp - 2 || d > exp + 2) begin
            nerr++;
            $display("FAIL %s: actual=%0d edges expected=%0d edges", req, d, exp);
        end
    endtask

    task automatic settle();
        repeat (40) @(negedge vco_clk);
    endtask

    task automatic kill_osc();
        osc_run = 0;
        #20;
        osc_good = 0;
        settle();
    endtask

    task automatic heal_osc();
        osc_run = 1;
        #40;
        osc_good = 1;
        settle();
    endtask

    task automatic t_reset();
        osc_good = 1;
        repeat (5) @(negedge vco_clk);
        chk("R1 scm_active", scm_active, 0);
        chk("R1 pll_sel_eff", pll_sel_eff, 0);
        chk("R1 mode_chg", mode_chg, 0);
        chk("R1 cm_rst_req", cm_rst_req, 0);
        rst_n = 1;
        settle();
    endtask

    task automatic t_normal_sel();
        chk_rate("R9 osc rate", RATE_OSC);
        pll_sel_req = 1;
        settle();
        chk("R9 pll_sel_eff set", pll_sel_eff, 1);
        chk_rate("R9 pll rate", RATE_PLL);
    endtask

    task automatic t_fallback();
        int p0 = pulse_cnt;
        kill_osc();
        chk("R2 scm_active", scm_active, 1);
        chk("R5 pll cleared", pll_sel_eff, 0);
        chk("R8 one pulse on entry", pulse_cnt - p0, 1);
        chk_rate("R2 vco rate", RATE_VCO);
    endtask

    task automatic t_hold();
        pll_sel_req = 0;
        settle();
        pll_sel_req = 1;
        settle();
        chk("R11 req edge ignored", pll_sel_eff, 0);
        scme = 0;
        settle();
        chk("R12 scme drop keeps fallback", scm_active, 1);
        chk("R12 no reset request", cm_rst_req, 0);
        scme = 1;
        settle();
    endtask

    task automatic t_recover();
        int p0 = pulse_cnt;
        heal_osc();
        chk("R6 back to normal", scm_active, 0);
        chk("R8 one pulse on exit", pulse_cnt - p0, 1);
        chk("R5 pll stays clear", pll_sel_eff, 0);
        chk_rate("R6 osc rate", RATE_OSC);
        pll_sel_req = 0;
        settle();
        pll_sel_req = 1;
        settle();
        chk("R5 re-raised request sets pll", pll_sel_eff, 1);
        pll_sel_req = 0;
        settle();
        chk("R9 low request clears pll", pll_sel_eff, 0);
    endtask

    task automatic t_no_monitor();
        cme = 0;
        settle();
        kill_osc();
        chk("R3 no fallback", scm_active, 0);
        chk("R3 no reset request", cm_rst_req, 0);
        chk_rate("R3 clock stays on dead osc", 0);
        heal_osc();
        cme = 1;
        settle();
    endtask

    task automatic t_reset_req();
        int p0;
        scme = 0;
        settle();
        p0 = pulse_cnt;
        kill_osc();
        chk("R4 reset request raised", cm_rst_req, 1);
        chk("R4 no fallback", scm_active, 0);
        chk("R8 no pulse without change", pulse_cnt - p0, 0);
        heal_osc();
        chk("R4 reset request drops", cm_rst_req, 0);
        scme = 1;
        settle();
    endtask

    task automatic t_startup();
        int p0;
        rst_n = 0;
        osc_run = 0;
        osc_good = 0;
        repeat (5) @(negedge vco_clk);
        p0 = pulse_cnt;
        rst_n = 1;
        settle();
        chk("R7 fallback from start-up", scm_active, 1);
        chk("R7 one pulse", pulse_cnt - p0, 1);
        chk_rate("R7 vco rate", RATE_VCO);
        heal_osc();
        chk("R7 normal once crystal runs", scm_active, 0);
        chk_rate("R7 osc rate", RATE_OSC);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal_sel();
        t_fallback();
        t_hold();
        t_recover();
        t_no_monitor();
        t_reset_req();
        t_startup();
        chk("R10 short sys_clk phases", glitch_cnt, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule